// File: doc/BRIEF.md
# Tag Check Failure Response Controller

This block sits behind a memory-tag comparator. When the comparator reports that a pointer's tag does not match the tag stored for its memory granule, the block decides how the core responds. The response depends on a two-bit check-fault mode and on whether the access was a read or a write. The mode is read from one of two fields of a 64-bit system control word. Which field is used depends on whether the failing access belongs to an unprivileged (EL0) translation regime.

The block responds in one of two ways. It can raise a one-cycle synchronous abort request that carries the failing address and a syndrome. It can instead set a sticky asynchronous fault flag. There is one flag pair per exception level, and software clears a level with a clear strobe. Taking the exception and vectoring to a handler are left to the surrounding core logic.

Top module: `tag_fail_resp`

## Requirements
- R1: After reset, `exc_req` is 0, `exc_addr` is 0, `exc_syndrome` is 0 and every bit of `async_flags` is 0.
- R2: When `fail_el0` is 1, the mode is taken from `ctrl_word[39:38]`. Otherwise it is taken from `ctrl_word[41:40]`. The field that is not selected has no effect.
- R3: In mode 1, every `fail_vld` makes `exc_req` high for exactly the following cycle, with `exc_addr` equal to the failing address. No flag changes.
- R4: In mode 2, a failure sets an asynchronous flag in the following cycle and never raises `exc_req`.
- R5: In mode 3, a write failure (`fail_write`=1) sets an asynchronous flag the way mode 2 does. A read failure raises a synchronous request the way mode 1 does.
- R6: In mode 0, a failure produces no request and leaves `async_flags` unchanged.
- R7: The flag set by an asynchronous response is `async_flags[2*L + B]`. L is 0 for an EL0-regime access and `cur_el` otherwise. B is `fail_addr[55]` when `fail_two_rng` is 1, and 0 otherwise.
- R8: Flags are sticky. A set flag stays set, and new failures OR further flags in, until a clear removes them.
- R9: `clr_vld` with `clr_el`=L clears both flags of level L in the next cycle and leaves the other levels as they are. A flag set in the same cycle as a clear of its own level ends up set.
- R10: While `exc_req` is high, `exc_syndrome[5:0]` is 0x11 and `exc_syndrome[6]` equals the write flag of the failing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_vld | input | 1 | Tag mismatch strobe, one cycle per failure |
| fail_addr | input | 64 | Address of the failing access |
| fail_write | input | 1 | 1 for a store, 0 for a load |
| fail_el0 | input | 1 | Failing access uses an EL0 regime |
| fail_two_rng | input | 1 | Regime has upper and lower address ranges |
| ctrl_word | input | 64 | System control word holding both mode fields |
| cur_el | input | 2 | Exception level owning the regime for non-EL0 accesses |
| clr_vld | input | 1 | Software clear strobe for one level's flags |
| clr_el | input | 2 | Level whose flags are cleared |
| exc_req | output | 1 | One-cycle synchronous abort request |
| exc_addr | output | 64 | Failing address reported with the request |
| exc_syndrome | output | 7 | Bit 6 write flag, bits 5:0 fault status code |
| async_flags | output | 8 | Sticky flags, two per level, level L at bits 2L+1:2L |

## Verification
The vector table covers every mode with both read and write accesses, in both EL0 and non-EL0 regimes. For each access, the unselected mode field holds the bitwise inverse of the selected one. A bench that picked the wrong field would therefore see mode 0 turn into mode 3, and mode 1 turn into mode 2, and the mismatch shows at the outputs. The vectors also vary the two-range flag, address bit 55 and the exception level, so each flag position is reached separately and a mix-up of level with bit is visible. Directed sequences check that two flags accumulate, that a clear affects only its own level, and that a set arriving in the same cycle as a clear of its level survives.

// File: rtl/tfr_pkg.sv
// Package: shared types and constants for the tag failure response block.
// Assumes a two-bit mode field and a six-bit fault status code.
package tfr_pkg;

    typedef enum logic [1:0] {
        TFR_OFF   = 2'd0,
        TFR_SYNC  = 2'd1,
        TFR_ASYNC = 2'd2,
        TFR_ASYM  = 2'd3
    } tfr_mode_e;

    localparam logic [5:0] TFR_FSC = 6'h11;

    typedef struct packed {
        logic take_sync;
        logic set_async;
    } tfr_action_t;

endpackage

// File: rtl/tfr_mode_sel.sv
// Module: tfr_mode_sel
// Picks the check-fault mode out of the control word. The position depends on
// whether the failing access used an EL0 regime. Assumes both fields are
// two bits wide and lie inside the word.
module tfr_mode_sel
    import tfr_pkg::*;
#(
    parameter int CTRL_W  = 64,
    parameter int EL0_LSB = 38,
    parameter int ELX_LSB = 40
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              el0_regime,
    output tfr_mode_e         mode
);

    logic ctrl_unused;
    assign ctrl_unused = ^ctrl_word;

    // Field select: the EL0 field for unprivileged regimes, the other field otherwise.
    always_comb begin
        if (el0_regime) mode = tfr_mode_e'(ctrl_word[EL0_LSB +: 2]);
        else            mode = tfr_mode_e'(ctrl_word[ELX_LSB +: 2]);
    end

endmodule

// File: rtl/tfr_resp_dec.sv
// Module: tfr_resp_dec
// Turns a failure strobe, the mode and the access kind into an action: a
// synchronous request, an asynchronous flag set, or nothing. It also works
// out which flag level and which flag bit an asynchronous response targets.
// Purely combinational.
module tfr_resp_dec
    import tfr_pkg::*;
#(
    parameter int NUM_LVL = 4,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic             fail_vld,
    input  tfr_mode_e        mode,
    input  logic             is_write,
    input  logic             el0_regime,
    input  logic             two_rng,
    input  logic             sel_addr_bit,
    input  logic [LVL_W-1:0] cur_el,
    output tfr_action_t      action,
    output logic [LVL_W-1:0] flag_lvl,
    output logic             flag_bit
);

    // Mode decision: mode 3 splits on direction, mode 0 does nothing.
    always_comb begin
        action = '0;
        if (fail_vld) begin
            unique case (mode)
                TFR_SYNC:  action.take_sync = 1'b1;
                TFR_ASYNC: action.set_async = 1'b1;
                TFR_ASYM: begin
                    action.set_async = is_write;
                    action.take_sync = !is_write;
                end
                default:   action = '0;
            endcase
        end
    end

    // Flag target: level 0 for EL0 regimes; the bit follows the range select when there are two ranges.
    always_comb begin
        flag_lvl = el0_regime ? '0 : cur_el;
        flag_bit = two_rng ? sel_addr_bit : 1'b0;
    end

endmodule

// File: rtl/tfr_sync_out.sv
// Module: tfr_sync_out
// Registers the synchronous abort request. The request is high for one
// cycle per triggering failure, and the address and syndrome are captured
// along with it. Assumes the request is consumed in that cycle.
module tfr_sync_out
    import tfr_pkg::*;
#(
    parameter int ADDR_W = 64,
    localparam int SYN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_sync,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [SYN_W-1:0]  exc_syndrome
);

    // Request pulse: follows the decision by one cycle and drops when no new failure arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) exc_req <= 1'b0;
        else        exc_req <= take_sync;
    end

    // Report capture: address and syndrome load only on a synchronous response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_addr     <= '0;
            exc_syndrome <= '0;
        end else if (take_sync) begin
            exc_addr     <= addr;
            exc_syndrome <= {is_write, TFR_FSC};
        end
    end

    p_syn_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_syndrome[5:0] == TFR_FSC);

    p_syn_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync |=> exc_syndrome[6] == $past(is_write));

endmodule

// File: rtl/tfr_status_bank.sv
// Module: tfr_status_bank
// Holds the sticky asynchronous fault flags, one group per exception level.
// A set ORs one bit into the chosen level. A clear wipes one level. When both
// hit the same level in the same cycle, the set bit survives.
module tfr_status_bank #(
    parameter int NUM_LVL = 4,
    parameter int RANGES  = 2,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int BIT_W  = $clog2(RANGES),
    localparam int FLAG_W = NUM_LVL * RANGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [LVL_W-1:0]  set_lvl,
    input  logic [BIT_W-1:0]  set_bit,
    input  logic              clr_vld,
    input  logic [LVL_W-1:0]  clr_lvl,
    output logic [FLAG_W-1:0] flags
);

    logic [RANGES-1:0] set_mask;

    // Set pattern: one-hot bit inside a level group.
    always_comb begin
        set_mask = '0;
        set_mask[set_bit] = 1'b1;
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic              hit_set;
        logic              hit_clr;
        logic [RANGES-1:0] q;

        assign hit_set = set_vld && (set_lvl == LVL_W'(g));
        assign hit_clr = clr_vld && (clr_lvl == LVL_W'(g));

        // Level register: clear first, then OR in the new set so the set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit_set || hit_clr) begin
                q <= (hit_clr ? '0 : q) | (hit_set ? set_mask : '0);
            end
        end

        assign flags[g*RANGES +: RANGES] = q;
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_vld |=> (flags & $past(flags)) == $past(flags));

    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> flags[$past(set_lvl) * RANGES + int'($past(set_bit))]);

endmodule

// File: rtl/tag_fail_resp.sv
// Module: tag_fail_resp
// Top of the tag check failure response controller. A mode select, an
// action decoder, a synchronous report register and a sticky flag bank are
// chained in that order. Assumes fail_vld is a single-cycle strobe per failure.
module tag_fail_resp
    import tfr_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CTRL_W    = 64,
    parameter int NUM_LVL   = 4,
    parameter int RANGE_BIT = 55,
    parameter int EL0_LSB   = 38,
    parameter int ELX_LSB   = 40,
    localparam int LVL_W    = $clog2(NUM_LVL),
    localparam int RANGES   = 2,
    localparam int FLAG_W   = NUM_LVL * RANGES,
    localparam int SYN_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_vld,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic              fail_write,
    input  logic              fail_el0,
    input  logic              fail_two_rng,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [LVL_W-1:0]  cur_el,
    input  logic              clr_vld,
    input  logic [LVL_W-1:0]  clr_el,
    output logic              exc_req,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [SYN_W-1:0]  exc_syndrome,
    output logic [FLAG_W-1:0] async_flags
);

    tfr_mode_e        mode;
    tfr_action_t      action;
    logic [LVL_W-1:0] flag_lvl;
    logic             flag_bit;

    tfr_mode_sel #(
        .CTRL_W  (CTRL_W),
        .EL0_LSB (EL0_LSB),
        .ELX_LSB (ELX_LSB)
    ) u_mode_sel (
        .ctrl_word  (ctrl_word),
        .el0_regime (fail_el0),
        .mode       (mode)
    );

    tfr_resp_dec #(
        .NUM_LVL (NUM_LVL)
    ) u_resp_dec (
        .fail_vld     (fail_vld),
        .mode         (mode),
        .is_write     (fail_write),
        .el0_regime   (fail_el0),
        .two_rng      (fail_two_rng),
        .sel_addr_bit (fail_addr[RANGE_BIT]),
        .cur_el       (cur_el),
        .action       (action),
        .flag_lvl     (flag_lvl),
        .flag_bit     (flag_bit)
    );

    tfr_sync_out #(
        .ADDR_W (ADDR_W)
    ) u_sync_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_sync    (action.take_sync),
        .addr         (fail_addr),
        .is_write     (fail_write),
        .exc_req      (exc_req),
        .exc_addr     (exc_addr),
        .exc_syndrome (exc_syndrome)
    );

    tfr_status_bank #(
        .NUM_LVL (NUM_LVL),
        .RANGES  (RANGES)
    ) u_status_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (action.set_async),
        .set_lvl (flag_lvl),
        .set_bit (flag_bit),
        .clr_vld (clr_vld),
        .clr_lvl (clr_el),
        .flags   (async_flags)
    );

    p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(fail_vld) && $past(mode) != TFR_OFF && $past(mode) != TFR_ASYNC);

    p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_addr == $past(fail_addr));

    p_async_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && mode == TFR_ASYNC) |=> !exc_req);

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && mode == TFR_OFF && !clr_vld) |=> !exc_req && async_flags == $past(async_flags));

    p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(action.take_sync && action.set_async));

endmodule

// File: tb/tag_fail_resp_bench.sv
`timescale 1ns/1ps
module tag_fail_resp_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       wr;
        logic       el0;
        logic       two;
        logic       a55;
        logic [1:0] el;
        logic       exp_req;
        logic       exp_set;
        logic [2:0] exp_idx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 3'd0},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 3'd0},
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 3'd1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 3'd4},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 3'd2},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 3'd0},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 3'd7},
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 3'd0},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0},
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fail_vld = 1'b0;
    logic [63:0] fail_addr = '0;
    logic        fail_write = 1'b0;
    logic        fail_el0 = 1'b0;
    logic        fail_two_rng = 1'b0;
    logic [63:0] ctrl_word = '0;
    logic [1:0]  cur_el = '0;
    logic        clr_vld = 1'b0;
    logic [1:0]  clr_el = '0;
    logic        exc_req;
    logic [63:0] exc_addr;
    logic [6:0]  exc_syndrome;
    logic [7:0]  async_flags;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tag_fail_resp u_tag_fail_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_vld     (fail_vld),
        .fail_addr    (fail_addr),
        .fail_write   (fail_write),
        .fail_el0     (fail_el0),
        .fail_two_rng (fail_two_rng),
        .ctrl_word    (ctrl_word),
        .cur_el       (cur_el),
        .clr_vld      (clr_vld),
        .clr_el       (clr_el),
        .exc_req      (exc_req),
        .exc_addr     (exc_addr),
        .exc_syndrome (exc_syndrome),
        .async_flags  (async_flags)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Selected field gets the mode, the other field gets its inverse.
    function automatic logic [63:0] make_ctrl(input logic [1:0] m, input logic el0);
        logic [63:0] w;
        w = 64'hF0F0_0000_0000_5A5A;
        if (el0) begin
            w[39:38] = m;
            w[41:40] = ~m;
        end else begin
            w[41:40] = m;
            w[39:38] = ~m;
        end
        return w;
    endfunction

    task automatic clear_all();
        for (int l = 0; l < 4; l++) begin
            @(negedge clk);
            clr_vld = 1'b1;
            clr_el  = 2'(l);
        end
        @(negedge clk);
        clr_vld = 1'b0;
    endtask

    task automatic fire(input logic [1:0] m, input logic wr, input logic el0, input logic two,
                        input logic a55, input logic [1:0] el, input logic [63:0] base);
        @(negedge clk);
        fail_vld     = 1'b1;
        fail_write   = wr;
        fail_el0     = el0;
        fail_two_rng = two;
        cur_el       = el;
        ctrl_word    = make_ctrl(m, el0);
        fail_addr    = base;
        fail_addr[55] = a55;
        @(negedge clk);
        fail_vld = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 exc_req", 64'(exc_req), 64'd0);
        chk("R1 exc_addr", exc_addr, 64'd0);
        chk("R1 exc_syndrome", 64'(exc_syndrome), 64'd0);
        chk("R1 async_flags", 64'(async_flags), 64'd0);

        // Table walk: R2..R7, R10
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [63:0] a;
            v = VECS[i];
            a = 64'h0012_3456_789A_BC00 + 64'(i * 16);
            a[55] = v.a55;
            clear_all();
            fire(v.mode, v.wr, v.el0, v.two, v.a55, v.el, a);
            chk($sformatf("R2/R3/R5 req vec%0d", i), 64'(exc_req), 64'(v.exp_req));
            chk($sformatf("R4/R6/R7 flags vec%0d", i), 64'(async_flags),
                v.exp_set ? (64'd1 << v.exp_idx) : 64'd0);
            if (v.exp_req) begin
                chk($sformatf("R3 addr vec%0d", i), exc_addr, a);
                chk($sformatf("R10 syndrome vec%0d", i), 64'(exc_syndrome), 64'({v.wr, 6'h11}));
            end
            @(negedge clk);
            chk($sformatf("R3 pulse vec%0d", i), 64'(exc_req), 64'd0);
        end

        // R8: two flags accumulate and stay
        clear_all();
        fire(2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 64'h100);
        fire(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 64'h200);
        repeat (3) @(negedge clk);
        chk("R8 sticky accumulate", 64'(async_flags), 64'h06);

        // R9: clear level 0 only
        clr_vld = 1'b1;
        clr_el  = 2'd0;
        @(negedge clk);
        clr_vld = 1'b0;
        chk("R9 clear one level", 64'(async_flags), 64'h04);

        // R9: set and clear of level 1 in the same cycle, set survives
        fail_vld     = 1'b1;
        fail_write   = 1'b0;
        fail_el0     = 1'b0;
        fail_two_rng = 1'b1;
        cur_el       = 2'd1;
        ctrl_word    = make_ctrl(2'd2, 1'b0);
        fail_addr    = 64'h0080_0000_0000_0300;
        clr_vld      = 1'b1;
        clr_el       = 2'd1;
        @(negedge clk);
        fail_vld = 1'b0;
        clr_vld  = 1'b0;
        chk("R9 set beats clear", 64'(async_flags), 64'h08);

        // R6: mode 0 leaves existing flags untouched
        fire(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 64'h400);
        chk("R6 off keeps flags", 64'(async_flags), 64'h08);
        chk("R6 off no req", 64'(exc_req), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule